// File: doc/BRIEF.md
# USB endpoint mode register slice with endpoint 0 write lock

This block holds the mode registers that a USB device serial interface engine consults to decide how each endpoint answers bus traffic. Software reaches the registers through a CPU port with a read strobe, a write strobe, an address and byte-wide data. The engine reaches them through an update port that carries:

- a token-phase-end strobe with the token type and new mode bits,
- markers for the start of a SETUP data phase and the start of the returned ACK,
- an ACK-completion pulse tagged with an endpoint index.

Endpoint 0, the control endpoint, is protected in two ways. An engine update locks its low seven bits against CPU writes until software reads the register. While its SETUP flag is high, CPU writes to the endpoint 0 data buffer are suppressed. Only the buffer's write-enable gate lives here. The other endpoints have plain mode registers with no lock. All registers are also presented in parallel to the engine.

Top module: `usbdev_ep_mode_regs`

## Requirements
- R1: After reset every register bit is zero, the lock is clear, every CPU read returns 0x00, and `ep_mode_o` is all zero.
- R2: On a cycle with `cpu_rd_i` high, `cpu_rdata_o` holds the addressed register from the next cycle on. An index of `NUM_EP` or above reads 0x00. `cpu_rdata_o` keeps its value on cycles without a read.
- R3: A token-end strobe with a valid type loads `eng_mode_i` into endpoint 0 bits [3:0] and locks the register. The valid types are OUT=01, IN=10 and SETUP=11. While the register is locked, CPU writes to endpoint 0 leave bits [6:0] unchanged.
- R4: A CPU read of endpoint 0 clears the lock, so a later CPU write takes effect. If the read coincides with an engine update, the lock stays set.
- R5: If an engine update and a CPU write to endpoint 0 land in the same cycle, the engine's values are kept, the CPU's bits [6:0] are dropped, and the lock is set.
- R6: Bits [6:5] of every register always read zero, whatever is written. Endpoint 0 has mode in [3:0], ACK in bit 4 and SETUP in bit 7.
- R7: An ACK-completion pulse for endpoint e sets bit 4 of register e. For endpoint 0 this counts as an engine update and sets the lock.
- R8: The start of a SETUP data phase sets endpoint 0 bit 7, which stays high until the ACK start marker, even through CPU writes. After that, any CPU write to endpoint 0 clears bit 7, even when the register is locked.
- R9: `buf_we_o` follows `cpu_buf_we_i`, except that it is low while endpoint 0 bit 7 is high or during the cycle of the SETUP data-phase start marker.
- R10: Registers 1 to `NUM_EP`-1 accept every CPU write at once, as stall in bit 7 and mode/ACK in [4:0], and are never locked.
- R11: A token-end strobe with type 00 changes nothing and does not lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_addr_i | input | IDX_W | CPU register index; 0 is the control endpoint |
| cpu_rd_i | input | 1 | CPU read strobe |
| cpu_wr_i | input | 1 | CPU write strobe |
| cpu_wdata_i | input | 8 | CPU write data |
| cpu_rdata_o | output | 8 | Registered read data |
| cpu_buf_we_i | input | 1 | CPU write request to the endpoint 0 buffer |
| buf_we_o | output | 1 | Gated buffer write enable |
| eng_tok_end_i | input | 1 | End of token phase for endpoint 0 |
| eng_tok_type_i | input | 2 | Token type: 00 none, 01 OUT, 10 IN, 11 SETUP |
| eng_mode_i | input | 4 | Mode bits written by the engine at token end |
| eng_setup_start_i | input | 1 | Start of SETUP data phase |
| eng_ack_start_i | input | 1 | Start of returned ACK packet |
| eng_ack_done_i | input | 1 | Transaction finished with ACK |
| eng_ack_ep_i | input | IDX_W | Endpoint of the finished transaction |
| ep_mode_o | output | 8*NUM_EP | All registers; endpoint n in bits [8n+7:8n] |

## Verification
The bench builds the block with its default of five endpoints, which gives a 3-bit index. This makes indices 5 to 7 reachable, covering out-of-range reads and writes and ACK pulses aimed at absent endpoints. Four non-control registers are enough to show that an ACK or a write reaches only the addressed one. Random cycles drive token ends, SETUP markers, reads and writes together, so that same-cycle collisions between engine and CPU occur many times.

// File: rtl/usbdev_ep_pkg.sv
package usbdev_ep_pkg;
  localparam int REG_W    = 8;
  localparam int MODE_W   = 4;
  localparam int ACK_BIT  = 4;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    TOK_NONE  = 2'b00,
    TOK_OUT   = 2'b01,
    TOK_IN    = 2'b10,
    TOK_SETUP = 2'b11
  } tok_e;
endpackage

// File: rtl/usbdev_ep0_reg.sv
module usbdev_ep0_reg
  import usbdev_ep_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_wr_i,
  input  logic              cpu_rd_i,
  input  logic [REG_W-1:0]  cpu_wdata_i,
  input  logic              eng_upd_i,
  input  logic [MODE_W-1:0] eng_mode_i,
  input  logic              ack_i,
  input  logic              setup_start_i,
  input  logic              ack_start_i,
  output logic [REG_W-1:0]  reg_o
);
  logic [MODE_W-1:0] mode_q;
  logic              ack_q, lock_q, setup_q, force_q;
  logic              upd;

  assign upd = eng_upd_i | ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      ack_q   <= 1'b0;
      lock_q  <= 1'b0;
      setup_q <= 1'b0;
      force_q <= 1'b0;
    end else begin
      if (upd) begin
        if (eng_upd_i) mode_q <= eng_mode_i;
        if (ack_i)     ack_q  <= 1'b1;
      end else if (cpu_wr_i && !lock_q) begin
        mode_q <= cpu_wdata_i[MODE_W-1:0];
        ack_q  <= cpu_wdata_i[ACK_BIT];
      end
      // engine update wins over a coinciding read
      if (upd)           lock_q <= 1'b1;
      else if (cpu_rd_i) lock_q <= 1'b0;
      if (setup_start_i)    force_q <= 1'b1;
      else if (ack_start_i) force_q <= 1'b0;
      // flag held while forced; any CPU write clears it afterwards
      if (setup_start_i || force_q) setup_q <= 1'b1;
      else if (cpu_wr_i)            setup_q <= 1'b0;
    end
  end

  assign reg_o = {setup_q, 2'b00, ack_q, mode_q};
endmodule

// File: rtl/usbdev_epn_reg.sv
module usbdev_epn_reg
  import usbdev_ep_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cpu_wr_i,
  input  logic [REG_W-1:0] cpu_wdata_i,
  input  logic             ack_i,
  output logic [REG_W-1:0] reg_o
);
  logic [REG_W-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (cpu_wr_i) nxt = {cpu_wdata_i[FLAG_BIT], 2'b00, cpu_wdata_i[ACK_BIT:0]};
    if (ack_i)    nxt[ACK_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign reg_o = q;
endmodule

// File: rtl/usbdev_ep_rd_port.sv
module usbdev_ep_rd_port
  import usbdev_ep_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int IDX_W  = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_i,
  input  logic [IDX_W-1:0]        addr_i,
  input  logic [NUM_EP*REG_W-1:0] regs_i,
  output logic [REG_W-1:0]        rdata_o
);
  logic [REG_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_EP; i++)
      if (addr_i == IDX_W'(i)) sel = regs_i[i*REG_W +: REG_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (rd_i) rdata_o <= sel;
  end
endmodule

// File: rtl/usbdev_ep_mode_regs.sv
module usbdev_ep_mode_regs
  import usbdev_ep_pkg::*;
#(
  parameter int NUM_EP = 5,
  localparam int IDX_W = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [IDX_W-1:0]        cpu_addr_i,
  input  logic                    cpu_rd_i,
  input  logic                    cpu_wr_i,
  input  logic [REG_W-1:0]        cpu_wdata_i,
  output logic [REG_W-1:0]        cpu_rdata_o,
  input  logic                    cpu_buf_we_i,
  output logic                    buf_we_o,
  input  logic                    eng_tok_end_i,
  input  logic [1:0]              eng_tok_type_i,
  input  logic [MODE_W-1:0]       eng_mode_i,
  input  logic                    eng_setup_start_i,
  input  logic                    eng_ack_start_i,
  input  logic                    eng_ack_done_i,
  input  logic [IDX_W-1:0]        eng_ack_ep_i,
  output logic [NUM_EP*REG_W-1:0] ep_mode_o
);
  logic [NUM_EP*REG_W-1:0] regs;
  logic                    tok_valid, sel0;

  assign tok_valid = eng_tok_end_i && (tok_e'(eng_tok_type_i) != TOK_NONE);
  assign sel0      = (cpu_addr_i == '0);

  usbdev_ep0_reg u_ep0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cpu_wr_i     (cpu_wr_i && sel0),
    .cpu_rd_i     (cpu_rd_i && sel0),
    .cpu_wdata_i  (cpu_wdata_i),
    .eng_upd_i    (tok_valid),
    .eng_mode_i   (eng_mode_i),
    .ack_i        (eng_ack_done_i && eng_ack_ep_i == '0),
    .setup_start_i(eng_setup_start_i),
    .ack_start_i  (eng_ack_start_i),
    .reg_o        (regs[REG_W-1:0])
  );

  for (genvar n = 1; n < NUM_EP; n++) begin : g_epn
    usbdev_epn_reg u_reg (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cpu_wr_i   (cpu_wr_i && cpu_addr_i == IDX_W'(n)),
      .cpu_wdata_i(cpu_wdata_i),
      .ack_i      (eng_ack_done_i && eng_ack_ep_i == IDX_W'(n)),
      .reg_o      (regs[n*REG_W +: REG_W])
    );
  end

  usbdev_ep_rd_port #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_rd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rd_i   (cpu_rd_i),
    .addr_i (cpu_addr_i),
    .regs_i (regs),
    .rdata_o(cpu_rdata_o)
  );

  // buffer write blocked while SETUP data may still be arriving
  assign buf_we_o  = cpu_buf_we_i && !regs[FLAG_BIT] && !eng_setup_start_i;
  assign ep_mode_o = regs;
endmodule

// File: rtl/usbdev_ep_mode_regs_chk.sv
module usbdev_ep_mode_regs_chk
  import usbdev_ep_pkg::*;
#(
  parameter int NUM_EP = 5,
  parameter int IDX_W  = 3
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [IDX_W-1:0]        cpu_addr_i,
  input logic                    cpu_rd_i,
  input logic                    cpu_wr_i,
  input logic [REG_W-1:0]        cpu_wdata_i,
  input logic                    cpu_buf_we_i,
  input logic                    buf_we_o,
  input logic                    eng_tok_end_i,
  input logic [1:0]              eng_tok_type_i,
  input logic [MODE_W-1:0]       eng_mode_i,
  input logic                    eng_setup_start_i,
  input logic                    eng_ack_start_i,
  input logic                    eng_ack_done_i,
  input logic [IDX_W-1:0]        eng_ack_ep_i,
  input logic [NUM_EP*REG_W-1:0] ep_mode_o,
  input logic                    ep0_lock,
  input logic                    ep0_force
);
  logic tok_ok, ack0, sel0;
  assign tok_ok = eng_tok_end_i && eng_tok_type_i != 2'b00;
  assign ack0   = eng_ack_done_i && eng_ack_ep_i == '0;
  assign sel0   = cpu_addr_i == '0;

  assert_tok_loads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_ok |=> ep0_lock && ep_mode_o[3:0] == $past(eng_mode_i));

  assert_locked_wr_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ep0_lock && cpu_wr_i && sel0 && !tok_ok && !ack0) |=> $stable(ep_mode_o[6:0]));

  assert_rd_unlocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_rd_i && sel0 && !tok_ok && !ack0) |=> !ep0_lock);

  assert_reserved_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ep_mode_o[6:5] == 2'b00);

  assert_ack0_locks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack0 |=> ep0_lock && ep_mode_o[ACK_BIT]);

  assert_setup_forced_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_setup_start_i || ep0_force) |=> ep_mode_o[FLAG_BIT]);

  assert_setup_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_wr_i && sel0 && !ep0_force && !eng_setup_start_i) |=> !ep_mode_o[FLAG_BIT]);

  assert_force_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_ack_start_i && !eng_setup_start_i) |=> !ep0_force);

  assert_buf_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_o |-> cpu_buf_we_i && !ep_mode_o[FLAG_BIT] && !eng_setup_start_i);

  for (genvar n = 1; n < NUM_EP; n++) begin : g_chk
    assert_epn_wr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cpu_wr_i && cpu_addr_i == IDX_W'(n) && !(eng_ack_done_i && eng_ack_ep_i == IDX_W'(n)))
      |=> ep_mode_o[n*REG_W +: REG_W] ==
          {$past(cpu_wdata_i[7]), 2'b00, $past(cpu_wdata_i[4:0])});
  end
endmodule

bind usbdev_ep_mode_regs usbdev_ep_mode_regs_chk #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .cpu_addr_i       (cpu_addr_i),
  .cpu_rd_i         (cpu_rd_i),
  .cpu_wr_i         (cpu_wr_i),
  .cpu_wdata_i      (cpu_wdata_i),
  .cpu_buf_we_i     (cpu_buf_we_i),
  .buf_we_o         (buf_we_o),
  .eng_tok_end_i    (eng_tok_end_i),
  .eng_tok_type_i   (eng_tok_type_i),
  .eng_mode_i       (eng_mode_i),
  .eng_setup_start_i(eng_setup_start_i),
  .eng_ack_start_i  (eng_ack_start_i),
  .eng_ack_done_i   (eng_ack_done_i),
  .eng_ack_ep_i     (eng_ack_ep_i),
  .ep_mode_o        (ep_mode_o),
  .ep0_lock         (u_ep0.lock_q),
  .ep0_force        (u_ep0.force_q)
);

// File: tb/sim_usbdev_ep_mode_regs.sv
`timescale 1ns/1ps
module sim_usbdev_ep_mode_regs;
  localparam int NUM_EP = 5;
  localparam int IDX_W  = 3;

  logic              clk = 1'b0, rst_ni = 1'b0;
  logic [IDX_W-1:0]  cpu_addr = '0, ack_ep = '0;
  logic              cpu_rd = 0, cpu_wr = 0, buf_we_req = 0;
  logic [7:0]        wdata = '0, rdata;
  logic              buf_we, tok_end = 0, setup_start = 0, ack_start = 0, ack_done = 0;
  logic [1:0]        tok_type = '0;
  logic [3:0]        eng_mode = '0;
  logic [NUM_EP*8-1:0] ep_mode;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] mreg [NUM_EP];
  bit         mlock, mforce;
  logic [7:0] mrd;

  always #2 clk = ~clk;

  usbdev_ep_mode_regs #(.NUM_EP(NUM_EP)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cpu_addr_i(cpu_addr), .cpu_rd_i(cpu_rd),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .cpu_buf_we_i(buf_we_req), .buf_we_o(buf_we), .eng_tok_end_i(tok_end),
    .eng_tok_type_i(tok_type), .eng_mode_i(eng_mode),
    .eng_setup_start_i(setup_start), .eng_ack_start_i(ack_start),
    .eng_ack_done_i(ack_done), .eng_ack_ep_i(ack_ep), .ep_mode_o(ep_mode));

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(int a);
    return (a < NUM_EP) ? mreg[a] : 8'h00;
  endfunction

  function automatic bit m_buf(bit req);
    return req && !mreg[0][7] && !setup_start;
  endfunction

  function automatic logic [NUM_EP*8-1:0] m_flat();
    logic [NUM_EP*8-1:0] f;
    for (int i = 0; i < NUM_EP; i++) f[i*8 +: 8] = mreg[i];
    return f;
  endfunction

  // one clock: drive at negedge, update model across the edge, check at next negedge
  task automatic cyc(string tag, int a, bit rd, bit wr, logic [7:0] wd, bit bq,
                     bit tk, logic [1:0] tt, logic [3:0] md, bit ss, bit as,
                     bit ad, int aep);
    bit upd0, tokv;
    logic [7:0] n0;
    cpu_addr = IDX_W'(a); cpu_rd = rd; cpu_wr = wr; wdata = wd; buf_we_req = bq;
    tok_end = tk; tok_type = tt; eng_mode = md; setup_start = ss;
    ack_start = as; ack_done = ad; ack_ep = IDX_W'(aep);
    #1;
    chk({"R9 ", tag}, buf_we, m_buf(bq));
    if (rd) mrd = m_read(a);
    tokv = tk && tt != 2'b00;
    upd0 = tokv || (ad && aep == 0);
    n0 = mreg[0];
    if (tokv) n0[3:0] = md;
    if (ad && aep == 0) n0[4] = 1'b1;
    if (!upd0 && wr && a == 0 && !mlock) n0[4:0] = wd[4:0];
    if (ss || mforce) n0[7] = 1'b1;
    else if (wr && a == 0) n0[7] = 1'b0;
    mlock  = upd0 ? 1'b1 : (rd && a == 0) ? 1'b0 : mlock;
    mforce = ss ? 1'b1 : as ? 1'b0 : mforce;
    mreg[0] = n0;
    for (int n = 1; n < NUM_EP; n++) begin
      if (wr && a == n) mreg[n] = {wd[7], 2'b00, wd[4:0]};
      if (ad && aep == n) mreg[n][4] = 1'b1;
    end
    @(negedge clk);
    chk({"ep_mode ", tag}, ep_mode, m_flat());
    chk({"rdata R2 ", tag}, rdata, mrd);
  endtask

  task automatic idle(string tag);
    cyc(tag, 0, 0, 0, 8'h00, 0, 0, 2'b00, 4'h0, 0, 0, 0, 0);
  endtask
  task automatic wr_reg(string tag, int a, logic [7:0] d);
    cyc(tag, a, 0, 1, d, 0, 0, 2'b00, 4'h0, 0, 0, 0, 0);
  endtask
  task automatic rd_reg(string tag, int a);
    cyc(tag, a, 1, 0, 8'h00, 0, 0, 2'b00, 4'h0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : stim
    for (int i = 0; i < NUM_EP; i++) mreg[i] = 8'h00;
    mlock = 0; mforce = 0; mrd = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 regs after reset", ep_mode, '0);
    chk("R1 rdata after reset", rdata, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) rd_reg("R1 read all", a);
    cyc("R1 buf pass", 0, 0, 0, 8'h00, 1, 0, 2'b00, 4'h0, 0, 0, 0, 0);

    wr_reg("R10 epn write", 2, 8'hFF);
    chk("R10 R6 ep2 value", ep_mode[16 +: 8], 8'h9F);
    wr_reg("R6 ep0 reserved", 0, 8'h6C);
    chk("R6 ep0 value", ep_mode[7:0], 8'h0C);

    cyc("R3 tok end", 0, 0, 0, 8'h00, 0, 1, 2'b01, 4'h5, 0, 0, 0, 0);
    wr_reg("R3 locked write", 0, 8'h0A);
    chk("R3 write ignored", ep_mode[7:0], 8'h05);
    wr_reg("R10 epn no lock", 3, 8'h83);
    chk("R10 ep3 value", ep_mode[24 +: 8], 8'h83);

    rd_reg("R4 unlock read", 0);
    chk("R4 read data", rdata, 8'h05);
    wr_reg("R4 write after read", 0, 8'h0A);
    chk("R4 write taken", ep_mode[7:0], 8'h0A);

    cyc("R5 collide", 0, 0, 1, 8'h13, 0, 1, 2'b10, 4'h7, 0, 0, 0, 0);
    chk("R5 engine wins", ep_mode[7:0], 8'h07);
    cyc("R4 read+tok", 0, 1, 0, 8'h00, 0, 1, 2'b11, 4'h2, 0, 0, 0, 0);
    wr_reg("R4 still locked", 0, 8'h0F);
    chk("R4 lock kept", ep_mode[7:0], 8'h02);

    rd_reg("R11 unlock", 0);
    cyc("R11 type none", 0, 0, 0, 8'h00, 0, 1, 2'b00, 4'h9, 0, 0, 0, 0);
    chk("R11 no load", ep_mode[7:0], 8'h02);
    wr_reg("R11 no lock", 0, 8'h04);
    chk("R11 write taken", ep_mode[7:0], 8'h04);

    cyc("R9 setup start", 0, 0, 0, 8'h00, 1, 0, 2'b00, 4'h0, 1, 0, 0, 0);
    chk("R8 flag set", ep_mode[7], 1'b1);
    cyc("R9 buf blocked", 0, 0, 1, 8'h00, 1, 0, 2'b00, 4'h0, 0, 0, 0, 0);
    chk("R8 held while forced", ep_mode[7], 1'b1);
    cyc("R8 ack start", 0, 0, 0, 8'h00, 1, 0, 2'b00, 4'h0, 0, 1, 0, 0);
    cyc("R8 tok lock", 0, 0, 0, 8'h00, 0, 1, 2'b11, 4'h1, 0, 0, 0, 0);
    wr_reg("R8 clear when locked", 0, 8'h80);
    chk("R8 flag cleared", ep_mode[7:0], 8'h01);
    cyc("R9 buf open", 0, 0, 0, 8'h00, 1, 0, 2'b00, 4'h0, 0, 0, 0, 0);

    cyc("R7 ack ep3", 0, 0, 0, 8'h00, 0, 0, 2'b00, 4'h0, 0, 0, 1, 3);
    chk("R7 ep3 ack", ep_mode[24 + 4], 1'b1);
    rd_reg("R7 unlock", 0);
    cyc("R7 ack ep0", 0, 0, 0, 8'h00, 0, 0, 2'b00, 4'h0, 0, 0, 1, 0);
    wr_reg("R7 locked by ack", 0, 8'h00);
    chk("R7 ep0 ack kept", ep_mode[7:0], 8'h11);
    cyc("R7 ack absent ep", 0, 0, 0, 8'h00, 0, 0, 2'b00, 4'h0, 0, 0, 1, 6);

    wr_reg("R2 out of range wr", 7, 8'hFF);
    rd_reg("R2 out of range", 6);
    chk("R2 zero read", rdata, 8'h00);
    idle("R2 hold");

    void'($urandom(32'h1234_5678));
    for (int k = 0; k < 4000; k++) begin
      cyc("R3 R4 R5 R7 R8 R10 R11 random",
          int'($urandom_range(0, 7)), ($urandom % 3) == 0, ($urandom % 3) == 0,
          8'($urandom), $urandom % 2, ($urandom % 6) == 0, 2'($urandom),
          4'($urandom), ($urandom % 20) == 0, ($urandom % 5) == 0,
          ($urandom % 7) == 0, int'($urandom_range(0, 7)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule